// File: doc/BRIEF.md
# Bit-Run Sequence Detector

This block takes a 32-bit packet into a holding register and searches it for stretches of equal neighbouring bits that a serial link could send as a single compressed symbol. The lowest eight bit positions are always sent bit by bit, so only positions 8 through 31 are searched. The search runs over three cycles. In each cycle a bank of eight XOR gates compares one window of eight positions with the bit just below each position.

A stapling stage carries a run that is still open at the right edge of a window into the next window. It closes a run as soon as a break appears, or when the packet ends. Each closed run of at least four bits becomes a record holding its start position and its length. Up to four records are kept, in ascending start order.

Once the records are final, a done flag rises. The flag stays high until the next packet is accepted. A read port returns any record selected by its index.

Top module: `bitrun_finder`

## Requirements
- R1: After reset, `load_ready` is 1, `done` is 0 and `run_count` is 0.
- R2: A packet is taken only on a clock edge where `load_valid` and `load_ready` are both 1. `load_ready` is 0 while a packet is being processed, and `load_valid` pulses in that time do not change the records that result.
- R3: Bits 0 to 7 of the packet have no effect on the records. A run that includes bit 8 is recorded as starting at 8, even when bit 7 has the same value.
- R4: A run is a maximal stretch of equal bits inside positions 8..31. It is recorded only when its length is 4 or more, so a 3-bit run yields no record.
- R5: A run that crosses the window edges between positions 15/16 or 23/24 is reported as one record, with its true start and full length.
- R6: At most 4 records are kept, in strictly ascending start order, and none of them overlap. Runs found after the table is full are dropped, and `run_count` stops at 4.
- R7: `done` rises exactly 5 clock edges after the edge that accepts a packet. It falls on the next accept, and `load_ready` is 1 while `done` is 1.
- R8: `rd_valid` is 1 exactly when `rd_idx` < `run_count`. `rd_start` is a 5-bit bit position, `rd_len` is a 5-bit bit count, and both read 0 for an index at or above `run_count`.
- R9: A packet whose bits 8..31 are all equal gives one record, with start 8 and length 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Packet offered |
| load_data | input | 32 | Packet bits, bit 0 first on the wire |
| load_ready | output | 1 | Block can take a packet |
| done | output | 1 | Records are final |
| rd_idx | input | 2 | Record index to read |
| rd_valid | output | 1 | Selected record exists |
| rd_start | output | 5 | Start bit position of the selected record |
| rd_len | output | 5 | Length of the selected record in bits |
| run_count | output | 3 | Number of records held (0..4) |

## Verification
Several properties are checked on every cycle by the assertions:
- no record emitted by the stapler is shorter than four bits;
- the table never exceeds its depth;
- the held records stay ordered and non-overlapping inside positions 8..31;
- unused table slots hold zero;
- the packet register does not change while the block is busy;
- the order of the phases from the last window, through the flush, to `done` is fixed.

Whether the records are the right ones for a given packet can only be shown by the bench's scenarios. These compare the records against a bit-serial reference for chosen and pseudo-random packets. They cover a run exactly four bits long, runs that span window edges, a table that overflows, changes to the low byte, and loads offered while busy.

// File: rtl/bitrun_pkg.sv
package bitrun_pkg;

  localparam int PKT_W   = 32;
  localparam int SKIP_W  = 8;
  localparam int WIN_W   = 8;
  localparam int MIN_RUN = 4;
  localparam int TBL_D   = 4;

  localparam int NWIN   = (PKT_W - SKIP_W) / WIN_W;
  localparam int POS_W  = $clog2(PKT_W);
  localparam int LEN_W  = $clog2(PKT_W - SKIP_W + 1);
  localparam int CNT_W  = $clog2(TBL_D + 1);
  localparam int IDX_W  = $clog2(TBL_D);
  localparam int OFF_W  = $clog2(WIN_W + 1);
  localparam int WSEL_W = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int NEMIT  = 3;

  typedef struct packed {
    logic [POS_W-1:0] start;
    logic [LEN_W-1:0] len;
  } run_rec_t;

  typedef struct packed {
    logic             head_cont;
    logic             inner;
    logic [OFF_W-1:0] head_len;
    logic             mid_ok;
    logic [OFF_W-1:0] mid_off;
    logic [OFF_W-1:0] mid_len;
    logic [OFF_W-1:0] tail_off;
  } win_info_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_FLUSH, S_WRAP, S_DONE
  } ctrl_st_t;

  function automatic logic [POS_W-1:0] window_base(input logic [WSEL_W-1:0] w);
    return POS_W'(SKIP_W) + POS_W'(w) * POS_W'(WIN_W);
  endfunction

  function automatic logic run_keep(input logic [LEN_W-1:0] len);
    return len >= LEN_W'(MIN_RUN);
  endfunction

  // Splits one window into a head segment (possibly joined to an open run),
  // at most one qualifying interior segment, and a tail left open.
  function automatic win_info_t scan_window(input logic [WIN_W-1:0] bits,
                                            input logic prev,
                                            input logic first);
    logic [WIN_W-1:0] brk;
    logic             cut;
    int               cs;
    win_info_t        r;
    r          = '0;
    brk[0]     = first | (bits[0] ^ prev);
    for (int k = 1; k < WIN_W; k++) brk[k] = bits[k] ^ bits[k-1];
    r.head_cont = ~brk[0];
    r.head_len  = OFF_W'(WIN_W);
    cs = 0;
    for (int p = 1; p <= WIN_W; p++) begin
      cut = (p == WIN_W) ? 1'b1 : brk[p % WIN_W];
      if (cut) begin
        if (p < WIN_W) begin
          if (cs == 0) begin
            r.inner    = 1'b1;
            r.head_len = OFF_W'(p);
          end else if (p - cs >= MIN_RUN) begin
            r.mid_ok  = 1'b1;
            r.mid_off = OFF_W'(cs);
            r.mid_len = OFF_W'(p - cs);
          end
          r.tail_off = OFF_W'(p);
        end
        cs = p;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/br_ctrl.sv
module br_ctrl
  import bitrun_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  output logic              accept,
  output logic              scan_fire,
  output logic              flush_fire,
  output logic [WSEL_W-1:0] win_sel,
  output logic              done
);

  ctrl_st_t state;

  assign load_ready = (state == S_IDLE) || (state == S_DONE);
  assign accept     = load_valid && load_ready;
  assign scan_fire  = (state == S_SCAN);
  assign flush_fire = (state == S_FLUSH);
  assign done       = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      win_sel <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (accept) begin
          state   <= S_SCAN;
          win_sel <= '0;
        end
        S_SCAN: begin
          if (win_sel == WSEL_W'(NWIN - 1)) state <= S_FLUSH;
          else win_sel <= win_sel + 1'b1;
        end
        S_FLUSH: state <= S_WRAP;
        S_WRAP:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  done_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(flush_fire, 2));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load_valid) |=> done);

  // R7
  last_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fire && win_sel == WSEL_W'(NWIN - 1)) |=> flush_fire);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!load_ready && scan_fire));

endmodule

// File: rtl/br_window_scan.sv
module br_window_scan
  import bitrun_pkg::*;
(
  input  logic [PKT_W-1:0]  pkt,
  input  logic [WSEL_W-1:0] win_sel,
  output win_info_t         info,
  output logic [POS_W-1:0]  base
);

  logic [WIN_W-1:0] bits;
  logic             prev;

  assign base = window_base(win_sel);
  assign bits = pkt[base +: WIN_W];
  assign prev = pkt[base - POS_W'(1)];
  assign info = scan_window(bits, prev, win_sel == '0);

endmodule

// File: rtl/br_stapler.sv
module br_stapler
  import bitrun_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              scan_fire,
  input  logic              flush_fire,
  input  win_info_t         info,
  input  logic [POS_W-1:0]  base,
  input  logic [IDX_W-1:0]  rd_idx,
  output run_rec_t          rd_rec,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  count
);

  run_rec_t         tbl   [TBL_D];
  run_rec_t         tbl_n [TBL_D];
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [POS_W-1:0] open_start, open_start_n;
  logic [LEN_W-1:0] open_len, open_len_n;

  logic [POS_W-1:0] joined_start;
  logic [LEN_W-1:0] joined_len;
  logic             keep_open;
  logic [NEMIT-1:0] emit_vld;
  run_rec_t         emit_rec [NEMIT];

  assign keep_open    = run_keep(open_len);
  assign joined_start = info.head_cont ? open_start : base;
  assign joined_len   = (info.head_cont ? open_len : '0) + LEN_W'(info.head_len);

  always_comb begin
    emit_vld[0] = (scan_fire && !info.head_cont && keep_open) || (flush_fire && keep_open);
    emit_rec[0] = run_rec_t'{start: open_start, len: open_len};
    emit_vld[1] = scan_fire && info.inner && run_keep(joined_len);
    emit_rec[1] = run_rec_t'{start: joined_start, len: joined_len};
    emit_vld[2] = scan_fire && info.inner && info.mid_ok;
    emit_rec[2] = run_rec_t'{start: base + POS_W'(info.mid_off), len: LEN_W'(info.mid_len)};
  end

  always_comb begin
    open_start_n = open_start;
    open_len_n   = open_len;
    if (flush_fire) begin
      open_start_n = '0;
      open_len_n   = '0;
    end else if (scan_fire) begin
      if (info.inner) begin
        open_start_n = base + POS_W'(info.tail_off);
        open_len_n   = LEN_W'(WIN_W) - LEN_W'(info.tail_off);
      end else begin
        open_start_n = joined_start;
        open_len_n   = joined_len;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < TBL_D; i++) tbl_n[i] = tbl[i];
    cnt_n = cnt;
    for (int e = 0; e < NEMIT; e++) begin
      if (emit_vld[e] && cnt_n < CNT_W'(TBL_D)) begin
        tbl_n[cnt_n[IDX_W-1:0]] = emit_rec[e];
        cnt_n = cnt_n + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < TBL_D; i++) tbl[i] <= '0;
      cnt        <= '0;
      open_start <= '0;
      open_len   <= '0;
    end else if (scan_fire || flush_fire) begin
      for (int i = 0; i < TBL_D; i++) tbl[i] <= tbl_n[i];
      cnt        <= cnt_n;
      open_start <= open_start_n;
      open_len   <= open_len_n;
    end
  end

  assign count    = cnt;
  assign rd_valid = CNT_W'(rd_idx) < cnt;
  assign rd_rec   = tbl[rd_idx];

  // R6
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TBL_D));

  generate
    for (genvar g = 0; g < NEMIT; g++) begin : g_emit_chk
      // R4
      emit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_vld[g] |-> (emit_rec[g].len >= LEN_W'(MIN_RUN)));
    end
    for (genvar g = 0; g < TBL_D; g++) begin : g_tbl_chk
      // R5
      span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > CNT_W'(g)) |-> (int'(tbl[g].start) >= SKIP_W &&
                               int'(tbl[g].start) + int'(tbl[g].len) <= PKT_W));
      // R8
      empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CNT_W'(g)) |-> (tbl[g] == '0));
      if (g > 0) begin : g_ord
        // R6
        order_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (cnt > CNT_W'(g)) |-> (int'(tbl[g].start) >=
                                 int'(tbl[g-1].start) + int'(tbl[g-1].len)));
      end
    end
  endgenerate

endmodule

// File: rtl/bitrun_finder.sv
module bitrun_finder
  import bitrun_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_valid,
  input  logic [31:0] load_data,
  output logic        load_ready,
  output logic        done,
  input  logic [1:0]  rd_idx,
  output logic        rd_valid,
  output logic [4:0]  rd_start,
  output logic [4:0]  rd_len,
  output logic [2:0]  run_count
);

  logic [PKT_W-1:0]  pkt_q;
  logic              accept, scan_fire, flush_fire;
  logic [WSEL_W-1:0] win_sel;
  win_info_t         info;
  logic [POS_W-1:0]  base;
  run_rec_t          rd_rec;

  always_ff @(posedge clk) begin
    if (!rst_n)      pkt_q <= '0;
    else if (accept) pkt_q <= load_data;
  end

  br_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_ready (load_ready),
    .accept     (accept),
    .scan_fire  (scan_fire),
    .flush_fire (flush_fire),
    .win_sel    (win_sel),
    .done       (done)
  );

  br_window_scan u_win (
    .pkt     (pkt_q),
    .win_sel (win_sel),
    .info    (info),
    .base    (base)
  );

  br_stapler u_staple (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept),
    .scan_fire  (scan_fire),
    .flush_fire (flush_fire),
    .info       (info),
    .base       (base),
    .rd_idx     (rd_idx),
    .rd_rec     (rd_rec),
    .rd_valid   (rd_valid),
    .count      (run_count)
  );

  assign rd_start = rd_rec.start;
  assign rd_len   = rd_rec.len;

  // R2
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ready |=> $stable(pkt_q));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (load_ready && !done && run_count == '0));

endmodule

// File: tb/tb_bitrun_finder.sv
module tb_bitrun_finder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic [31:0] load_data = '0;
  logic [1:0]  rd_idx = '0;
  logic        load_ready, done, rd_valid;
  logic [4:0]  rd_start, rd_len;
  logic [2:0]  run_count;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt;
  int exp_st [4];
  int exp_ln [4];

  always #2 clk = ~clk;

  bitrun_finder dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .load_ready(load_ready), .done(done), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_start(rd_start), .rd_len(rd_len), .run_count(run_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bit-serial reference walk over positions 8..31.
  task automatic model(input logic [31:0] d);
    int s;
    bit cut;
    exp_cnt = 0;
    for (int i = 0; i < 4; i++) begin exp_st[i] = 0; exp_ln[i] = 0; end
    s = 8;
    for (int p = 9; p <= 32; p++) begin
      cut = (p == 32) ? 1'b1 : (d[p % 32] != d[p - 1]);
      if (cut) begin
        if (p - s >= 4 && exp_cnt < 4) begin
          exp_st[exp_cnt] = s;
          exp_ln[exp_cnt] = p - s;
          exp_cnt++;
        end
        s = p;
      end
    end
  endtask

  // Offers d; optionally offers alt while busy (R2). Checks done timing (R7).
  task automatic send(input logic [31:0] d, input bit glitch, input logic [31:0] alt);
    @(negedge clk);
    chk("R7 ready before load", int'(load_ready), 1);
    load_valid = 1'b1;
    load_data  = d;
    @(posedge clk);
    @(negedge clk);
    load_valid = glitch;
    load_data  = alt;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 3) load_valid = 1'b0;
      chk("R7 done timing", int'(done), (k == 5) ? 1 : 0);
      chk("R2 ready while busy", int'(load_ready), (k == 5) ? 1 : 0);
    end
  endtask

  task automatic read_table(input string req);
    chk({req, " count"}, int'(run_count), exp_cnt);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd_idx = 2'(i);
      #1;
      chk("R8 rd_valid", int'(rd_valid), (i < exp_cnt) ? 1 : 0);
      chk({req, " start"}, int'(rd_start), exp_st[i]);
      chk({req, " len"}, int'(rd_len), exp_ln[i]);
    end
  endtask

  task automatic run_case(input logic [31:0] d, input string req);
    model(d);
    send(d, 1'b0, '0);
    read_table(req);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 ready", int'(load_ready), 1);
    chk("R1 done", int'(done), 0);
    chk("R1 count", int'(run_count), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_all_equal;
    run_case(32'h0000_0000, "R9");
    chk("R9 explicit count", exp_cnt, 1);
    chk("R9 explicit start", exp_st[0], 8);
    chk("R9 explicit len", exp_ln[0], 24);
    run_case(32'hFFFF_FF00, "R9 ones");
  endtask

  task automatic t_short_runs;
    run_case(32'hAAAA_AAAA, "R4 alternating");
    chk("R4 alternating none", int'(run_count), 0);
    run_case(32'h5555_5700, "R4 three-bit run");
    chk("R4 three-bit run none", int'(run_count), 0);
  endtask

  task automatic t_cross;
    run_case(32'hAAAF_F200, "R5 cross 15/16");
    chk("R5 single record", int'(run_count), 1);
    rd_idx = 2'd0; #1;
    chk("R5 start 12", int'(rd_start), 12);
    chk("R5 len 8", int'(rd_len), 8);
    run_case(32'hFFFF_F5AA, "R5 cross both edges");
  endtask

  task automatic t_overflow;
    run_case(32'h0F0F_0F0F, "R6 overflow");
    chk("R6 capped count", int'(run_count), 4);
    rd_idx = 2'd3; #1;
    chk("R6 last kept start", int'(rd_start), 20);
  endtask

  task automatic t_low_bits;
    int s1, l1;
    run_case(32'hFFFF_FF80, "R3 bit7 equal");
    rd_idx = 2'd0; #1;
    chk("R3 start at 8", int'(rd_start), 8);
    chk("R3 len 24", int'(rd_len), 24);
    run_case(32'hC3F0_0E00, "R3 low zero");
    rd_idx = 2'd0; #1;
    s1 = int'(rd_start); l1 = int'(rd_len);
    run_case(32'hC3F0_0EFF, "R3 low ones");
    rd_idx = 2'd0; #1;
    chk("R3 low byte ignored start", int'(rd_start), s1);
    chk("R3 low byte ignored len", int'(rd_len), l1);
  endtask

  task automatic t_busy;
    model(32'h00FF_F0A5);
    send(32'h00FF_F0A5, 1'b1, 32'h5555_5555);
    read_table("R2 busy load ignored");
  endtask

  task automatic t_random;
    logic [31:0] x;
    x = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      run_case((n % 3 == 0) ? (x & (x >> 3) & (x << 2)) : x, "R4 R5 R6 random");
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_all_equal();
    t_short_runs();
    t_cross();
    t_overflow();
    t_low_bits();
    t_busy();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule